// File: doc/BRIEF.md
# Register-Bank Bus Slave with Range Checking

This block is a bus slave in the AHB-Lite style that fronts a bank of word-wide registers. A master selects it, places an address and control in the address phase, and then sees a fixed number of wait states while an internal state machine steps through its phases: it checks the request, decodes the working address, performs the access, and then responds. Reads return the stored word on the read-data bus in the cycle where ready rises. Writes take the write data from the data phase.

Every request is screened before it touches the bank. A word index at or past the bank depth, an address that is not word aligned, or a transfer size wider than the bus is answered with the two-cycle ERROR response, and the bank is left untouched. A sequential beat ignores the bus address and uses an address the slave keeps itself. That address is one word past the last beat that completed, so a burst runs through consecutive registers and fails cleanly if it runs off the end of the bank.

Top module: `ahb_rf_slave`

## Requirements
- R1: While reset is low and after it is released, HREADYOUT is 1 and HRESP is 0 (OKAY). Reset clears every register to zero and clears the retained sequential word index to 0.
- R2: HTRANS codes are 00 IDLE, 01 BUSY, 10 NONSEQ and 11 SEQ. An IDLE or BUSY cycle, or any cycle with HSEL low, starts no transfer. The next cycle shows HREADYOUT 1 with OKAY, and no register changes.
- R3: A write stores the HWDATA value presented in the data phase into the addressed word, and a later read of that word returns it on HRDATA.
- R4: An accepted transfer that passes the checks holds HREADYOUT low for exactly 3 cycles after its address phase. It then shows HREADYOUT 1 with HRESP 0, and for a read the word is valid on HRDATA in that cycle.
- R5: A NONSEQ transfer whose word index (HADDR divided by 4) is 256 or more gets an ERROR response and writes nothing.
- R6: HRESP is 0 for OKAY and 1 for ERROR. An ERROR is one cycle with HREADYOUT 0 and HRESP 1, followed by one cycle with HREADYOUT 1 and HRESP 1, and the first of these comes in the second cycle after the address phase.
- R7: A SEQ transfer ignores HADDR's word index and uses the retained index, which is one more than the word index of the last transfer that completed with OKAY. An ERROR leaves the retained index unchanged.
- R8: A SEQ transfer whose retained index has reached 256 gets an ERROR response.
- R9: An HSIZE code above 2 (wider than 32 bits), or HADDR bits [1:0] not zero, gives an ERROR response with no write. Sizes 0 to 2 that are aligned access the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | 32 | Byte address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 = write, 0 = read |
| hsize_i | input | 3 | Transfer size code |
| hwdata_i | input | 32 | Write data, data phase |
| hrdata_o | output | 32 | Read data |
| hreadyout_o | output | 1 | Transfer done / slave ready |
| hresp_o | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The bench targets the bank edges: word 255 must be accepted, and word 256 must be refused, whether it is reached by a NONSEQ address or by a SEQ beat carried over from word 255. A design with an off-by-one compare or a wrapping index would instead write word 0 or silently accept the transfer. It also sends SEQ beats with an unrelated HADDR, to catch a design that decodes HADDR instead of the retained index, and it sends IDLE and BUSY cycles with a write pending and then reads the target back, to catch a slave that acts on them. It further checks the exact wait-state count and both cycles of the ERROR form, so a design that drops the low-ready first cycle or ends the error early is reported.

// File: rtl/ahb_rf_pkg.sv
package ahb_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DECODE,
    ST_WRITE,
    ST_READ,
    ST_RESP,
    ST_ERR_LO,
    ST_ERR_HI
  } rf_state_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

endpackage

// File: rtl/ahb_rf_bank.sv
module ahb_rf_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] row_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q[g] <= '0;
      end else if (we_i && (waddr_i == IDX_W'(g))) begin
        row_q[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      rdata_q <= row_q[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/ahb_rf_ctrl.sv
module ahb_rf_ctrl
  import ahb_rf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OFS_W  = $clog2(DATA_W / 8),
  localparam int WORD_W = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic [DATA_W-1:0] hwdata_i,
  output logic              hreadyout_o,
  output logic              hresp_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              re_o,
  output logic [IDX_W-1:0]  raddr_o
);

  rf_state_e state_q, state_d;

  logic [WORD_W-1:0] req_word_q;
  logic              req_seq_q;
  logic              req_write_q;
  logic              req_form_bad_q;
  logic [IDX_W:0]    next_idx_q;
  logic [IDX_W-1:0]  work_idx_q;

  logic              take;
  logic              form_bad;
  logic [WORD_W-1:0] sel_word;
  logic              sel_in_range;

  assign hreadyout_o = (state_q == ST_IDLE) || (state_q == ST_RESP) ||
                       (state_q == ST_ERR_HI);
  assign hresp_o     = ((state_q == ST_ERR_LO) || (state_q == ST_ERR_HI)) ?
                       RESP_ERROR : RESP_OKAY;

  assign take     = hreadyout_o && hsel_i && htrans_i[1];
  assign form_bad = (hsize_i > 3'(OFS_W)) || (haddr_i[OFS_W-1:0] != '0);

  // sequential beats use the retained index, not the bus address
  assign sel_word     = req_seq_q ? WORD_W'(next_idx_q) : req_word_q;
  assign sel_in_range = sel_word < WORD_W'(DEPTH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RESP, ST_ERR_HI: state_d = take ? ST_CHECK : ST_IDLE;
      ST_CHECK:  state_d = (req_form_bad_q || !sel_in_range) ? ST_ERR_LO : ST_DECODE;
      ST_DECODE: state_d = req_write_q ? ST_WRITE : ST_READ;
      ST_WRITE:  state_d = ST_RESP;
      ST_READ:   state_d = ST_RESP;
      ST_ERR_LO: state_d = ST_ERR_HI;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // address-phase capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_word_q     <= '0;
      req_seq_q      <= 1'b0;
      req_write_q    <= 1'b0;
      req_form_bad_q <= 1'b0;
    end else if (take) begin
      req_word_q     <= haddr_i[ADDR_W-1:OFS_W];
      req_seq_q      <= (htrans_i == TR_SEQ);
      req_write_q    <= hwrite_i;
      req_form_bad_q <= form_bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_idx_q <= '0;
    end else if (state_q == ST_DECODE) begin
      work_idx_q <= sel_word[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_idx_q <= '0;
    end else if ((state_q == ST_WRITE) || (state_q == ST_READ)) begin
      next_idx_q <= {1'b0, work_idx_q} + 1'b1;
    end
  end

  assign we_o    = (state_q == ST_WRITE);
  assign waddr_o = work_idx_q;
  assign wdata_o = hwdata_i;
  assign re_o    = (state_q == ST_READ);
  assign raddr_o = work_idx_q;

endmodule

// File: rtl/ahb_rf_slave.sv
module ahb_rf_slave #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic [DATA_W-1:0] hwdata_i,
  output logic [DATA_W-1:0] hrdata_o,
  output logic              hreadyout_o,
  output logic              hresp_o
);

  logic              bank_we;
  logic [IDX_W-1:0]  bank_waddr;
  logic [DATA_W-1:0] bank_wdata;
  logic              bank_re;
  logic [IDX_W-1:0]  bank_raddr;

  ahb_rf_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsel_i     (hsel_i),
    .haddr_i    (haddr_i),
    .htrans_i   (htrans_i),
    .hwrite_i   (hwrite_i),
    .hsize_i    (hsize_i),
    .hwdata_i   (hwdata_i),
    .hreadyout_o(hreadyout_o),
    .hresp_o    (hresp_o),
    .we_o       (bank_we),
    .waddr_o    (bank_waddr),
    .wdata_o    (bank_wdata),
    .re_o       (bank_re),
    .raddr_o    (bank_raddr)
  );

  ahb_rf_bank #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we),
    .waddr_i(bank_waddr),
    .wdata_i(bank_wdata),
    .re_i   (bank_re),
    .raddr_i(bank_raddr),
    .rdata_o(hrdata_o)
  );

endmodule

// File: rtl/ahb_rf_checker.sv
module ahb_rf_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int OFS_W = $clog2(DATA_W / 8)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsel_i,
  input logic [ADDR_W-1:0] haddr_i,
  input logic [1:0]        htrans_i,
  input logic [2:0]        hsize_i,
  input logic              hreadyout_o,
  input logic              hresp_o
);

  logic start, oor, form_ok;
  assign start   = hreadyout_o && hsel_i && htrans_i[1];
  assign oor     = haddr_i[ADDR_W-1:OFS_W] >= (ADDR_W-OFS_W)'(DEPTH);
  assign form_ok = (hsize_i <= 3'(OFS_W)) && (haddr_i[OFS_W-1:0] == '0);

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (hreadyout_o && !hresp_o)); // R1

  AST_IDLE_ZERO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreadyout_o && !(hsel_i && htrans_i[1])) |=> (hreadyout_o && !hresp_o)); // R2

  AST_WAIT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!hreadyout_o && !hresp_o)); // R4

  AST_OK_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && htrans_i == 2'b10 && !oor && form_ok) |=> ##3 (hreadyout_o && !hresp_o)); // R4

  AST_OOR_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && htrans_i == 2'b10 && oor) |=> ##1 (hresp_o && !hreadyout_o)); // R5

  AST_ERR_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hreadyout_o) |=> (hresp_o && hreadyout_o)); // R6

  AST_ERR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && hreadyout_o) |-> $past(hresp_o && !hreadyout_o)); // R6

  AST_BAD_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !form_ok) |=> ##1 (hresp_o && !hreadyout_o)); // R9

endmodule

bind ahb_rf_slave ahb_rf_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hsel_i     (hsel_i),
  .haddr_i    (haddr_i),
  .htrans_i   (htrans_i),
  .hsize_i    (hsize_i),
  .hreadyout_o(hreadyout_o),
  .hresp_o    (hresp_o)
);

// File: tb/tb_ahb_rf_slave.sv
module tb_ahb_rf_slave;

  localparam int DEPTH = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsel_i = 1'b0;
  logic [31:0] haddr_i = '0;
  logic [1:0]  htrans_i = 2'b00;
  logic        hwrite_i = 1'b0;
  logic [2:0]  hsize_i = 3'd2;
  logic [31:0] hwdata_i = '0;
  logic [31:0] hrdata_o;
  logic        hreadyout_o;
  logic        hresp_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] ref_mem [DEPTH];
  int          ref_next;

  always #10 clk_i = ~clk_i;

  ahb_rf_slave dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsel_i     (hsel_i),
    .haddr_i    (haddr_i),
    .htrans_i   (htrans_i),
    .hwrite_i   (hwrite_i),
    .hsize_i    (hsize_i),
    .hwdata_i   (hwdata_i),
    .hrdata_o   (hrdata_o),
    .hreadyout_o(hreadyout_o),
    .hresp_o    (hresp_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected outcome: 1 = error; idx = selected word
  function automatic bit model_bad(input logic [1:0] tr, input logic [31:0] a,
                                   input logic [2:0] sz, output int idx);
    idx = (tr == 2'b11) ? ref_next : int'(a >> 2);
    return (sz > 3'd2) || (a[1:0] != 2'b00) || (idx >= DEPTH);
  endfunction

  // call at negedge with hreadyout high; returns at negedge with hreadyout high
  task automatic run(input bit w, input logic [1:0] tr, input logic [31:0] a,
                     input logic [2:0] sz, input logic [31:0] d, input string req);
    int  idx;
    bit  bad;
    int  lows;
    bit  err_low;
    bad = model_bad(tr, a, sz, idx);
    hsel_i = 1'b1; htrans_i = tr; haddr_i = a; hwrite_i = w; hsize_i = sz;
    @(posedge clk_i);
    @(negedge clk_i);
    hsel_i = 1'b0; htrans_i = 2'b00; hwdata_i = d;
    lows = 0; err_low = 1'b0;
    while (!hreadyout_o && lows < 20) begin
      lows++;
      if (hresp_o) err_low = 1'b1;
      @(negedge clk_i);
    end
    if (bad) begin
      chk(lows == 2, req, "error wait cycles", 32'(lows), 32'd2);
      chk(err_low, req, "error first cycle resp", {31'd0, err_low}, 32'd1);
      chk(hresp_o == 1'b1, req, "error resp", {31'd0, hresp_o}, 32'd1);
    end else begin
      chk(lows == 3, req, "wait cycles", 32'(lows), 32'd3);
      chk(hresp_o == 1'b0 && !err_low, req, "okay resp", {31'd0, hresp_o}, 32'd0);
      if (w) ref_mem[idx] = d;
      else chk(hrdata_o === ref_mem[idx], req, "read data", hrdata_o, ref_mem[idx]);
      ref_next = idx + 1;
    end
  endtask

  task automatic idle_cycle(input logic [1:0] tr, input logic [31:0] a, input string req);
    hsel_i = 1'b1; htrans_i = tr; haddr_i = a; hwrite_i = 1'b1; hsize_i = 3'd2;
    hwdata_i = 32'hDEAD_BEEF;
    @(posedge clk_i);
    @(negedge clk_i);
    hsel_i = 1'b0; htrans_i = 2'b00;
    chk(hreadyout_o && !hresp_o, req, "zero-wait okay", {30'd0, hreadyout_o, hresp_o}, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected none");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    ref_next = 0;
    repeat (3) @(negedge clk_i);
    chk(hreadyout_o && !hresp_o, "R1", "ready/resp in reset", {30'd0, hreadyout_o, hresp_o}, 32'h2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(hreadyout_o && !hresp_o, "R1", "ready/resp after reset", {30'd0, hreadyout_o, hresp_o}, 32'h2);

    // R1: cleared bank
    run(1'b0, 2'b10, 32'h0000_0000, 3'd2, '0, "R1");
    run(1'b0, 2'b10, 32'h0000_03FC, 3'd2, '0, "R1");

    // R3 R4: write then read back, word 255 boundary accepted
    run(1'b1, 2'b10, 32'h0000_0014, 3'd2, 32'hA5A5_0001, "R3");
    run(1'b1, 2'b10, 32'h0000_03FC, 3'd2, 32'h1234_5678, "R4");
    run(1'b0, 2'b10, 32'h0000_0014, 3'd2, '0, "R3");
    run(1'b0, 2'b10, 32'h0000_03FC, 3'd2, '0, "R4");

    // R2: IDLE and BUSY with a write pending do nothing
    idle_cycle(2'b00, 32'h0000_001C, "R2");
    idle_cycle(2'b01, 32'h0000_001C, "R2");
    run(1'b0, 2'b10, 32'h0000_001C, 3'd2, '0, "R2");

    // R5 R6: word 256 and beyond
    run(1'b1, 2'b10, 32'h0000_0400, 3'd2, 32'hFFFF_0000, "R5");
    run(1'b0, 2'b10, 32'h0001_0000, 3'd2, '0, "R6");
    run(1'b0, 2'b10, 32'h0000_0000, 3'd2, '0, "R5");

    // R7: SEQ follows the retained index, HADDR ignored
    run(1'b1, 2'b10, 32'h0000_0028, 3'd2, 32'h0000_0A0A, "R7");
    run(1'b1, 2'b11, 32'h0000_0F00, 3'd2, 32'h0000_0B0B, "R7");
    run(1'b1, 2'b11, 32'h0000_0100, 3'd2, 32'h0000_0C0C, "R7");
    run(1'b0, 2'b10, 32'h0000_002C, 3'd2, '0, "R7");
    run(1'b0, 2'b10, 32'h0000_0030, 3'd2, '0, "R7");

    // R8: SEQ off the end of the bank, twice
    run(1'b1, 2'b10, 32'h0000_03FC, 3'd2, 32'h7777_7777, "R8");
    run(1'b1, 2'b11, 32'h0000_0000, 3'd2, 32'h8888_8888, "R8");
    run(1'b0, 2'b11, 32'h0000_0000, 3'd2, '0, "R8");
    run(1'b0, 2'b10, 32'h0000_0000, 3'd2, '0, "R8");

    // R9: oversize and misaligned are refused, nothing written
    run(1'b1, 2'b10, 32'h0000_0050, 3'd3, 32'h9999_9999, "R9");
    run(1'b1, 2'b10, 32'h0000_0052, 3'd2, 32'h9999_9999, "R9");
    run(1'b0, 2'b10, 32'h0000_0050, 3'd2, '0, "R9");
    run(1'b1, 2'b10, 32'h0000_0054, 3'd0, 32'h0101_0101, "R9");
    run(1'b0, 2'b10, 32'h0000_0054, 3'd2, '0, "R9");

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit          w;
      logic [1:0]  tr;
      logic [31:0] a;
      logic [2:0]  sz;
      int          r;
      w  = 1'($urandom_range(0, 1));
      tr = ($urandom_range(0, 9) < 3) ? 2'b11 : 2'b10;
      r  = int'($urandom_range(0, 99));
      if (r < 5)       a = 32'($urandom_range(256, 300)) << 2;
      else if (r < 9) a = (32'($urandom_range(0, 255)) << 2) | 32'd1;
      else if (r < 20) a = 32'($urandom_range(248, 255)) << 2;
      else             a = 32'($urandom_range(0, 255)) << 2;
      sz = ($urandom_range(0, 19) == 0) ? 3'd4 : 3'd2;
      if ($urandom_range(0, 9) == 0) idle_cycle(2'($urandom_range(0, 1)), a, "R2");
      run(w, tr, a, sz, $urandom, "R3 R4 R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule